// File: doc/BRIEF.md
# Port 0x80 Postcode Display Target

This block is a small PCI target that listens for single I/O transactions at the legacy diagnostic port 0x00000080. When the port is written, the block stores the low byte and shows it as two hexadecimal digits on a pair of seven-segment outputs. It claims reads of that port as well and returns the stored byte, so a master that probes the port never ends in a master abort. The block has no base address registers: the port address is a fixed parameter. It also answers type-0 configuration cycles from a small constant register space.

The bus is modelled with separate input, output and output-enable signals for the shared lines. The surrounding pad logic builds the tristate drivers from these. The block uses medium device-select timing. It finishes exactly one data phase per transaction. If the master still holds FRAME# low during that phase, the block disconnects with data. Any transaction that the block does not claim is tracked until the bus goes idle. While it is tracked, none of its data phases is mistaken for an address phase.

Top module: `postcode_target`

## Requirements
- R1: Reset gives the following state: devsel_n, trdy_n and stop_n are high, and ctl_oe, ad_oe and par_oe are low. The stored byte is 0x00, so both segment outputs show the digit 0 (7'h3F).
- R2: The address phase of a claimed cycle is the clock edge at which frame_n is low, irdy_n is high and cbe_n[3:1] is 3'b001 (an I/O command). For an I/O cycle, ad_in must also equal 0x00000080. On such a cycle, devsel_n and trdy_n are low, with ctl_oe high, when sampled after the second edge following that address phase (medium timing).
- R3: An I/O write is cbe_n = 4'b0011. In its data phase, cbe_n[0] low enables byte lane 0. When such a data phase completes, ad_in[7:0] is stored. One clock later seg_lo shows bits 3:0 and seg_hi shows bits 7:4. Segments are active high, with bit 0 = a through bit 6 = g.
- R4: An I/O write whose data-phase cbe_n[0] is high is still claimed, but it leaves the stored byte and the displays unchanged.
- R5: An I/O read (cbe_n = 4'b0010) of the port is claimed. While trdy_n is low, ad_oe is high and ad_out holds 24 zero bits above the stored byte.
- R6: A cycle is not claimed if its I/O address differs from 0x00000080 in any bit, or if its command is not I/O or configuration. For such a cycle, devsel_n stays high.
- R7: The data phases of an unclaimed transaction are ignored, even when they carry an address and command that match the port. The block waits for frame_n and irdy_n to both be high before it decodes again.
- R8: A configuration cycle is claimed only when idsel is high, cbe_n[3:1] is 3'b101 and ad_in[1:0] is 2'b00 in the address phase.
- R9: A configuration read returns a value selected by the dword index ad_in[7:2]. Dword 0 returns {DEVICE_ID, VENDOR_ID}, and dword 2 returns {CLASS_CODE, REV_ID}. Every other dword, including indices 4 to 9, returns zero.
- R10: A configuration write is claimed and completed. It changes neither the configuration values nor the stored byte.
- R11: For each completed read data phase, par carries even parity over ad_out and cbe_n of that phase, with par_oe high for exactly the one following clock. par_oe stays low after writes.
- R12: If frame_n is low at the first edge after the address phase, stop_n is asserted together with trdy_n. After the transfer, stop_n and devsel_n stay low, with trdy_n high, until frame_n returns high.
- R13: While irdy_n stays high in the data phase, no transfer happens: trdy_n and devsel_n remain low.
- R14: After a transaction ends, devsel_n, trdy_n and stop_n are driven high for one clock with ctl_oe high. ctl_oe is then released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 32 | Address/data lines as seen from the bus |
| ad_out | output | 32 | Read data driven onto the address/data lines |
| ad_oe | output | 1 | Output enable for ad_out |
| cbe_n | input | 4 | Command / byte enables, active low |
| frame_n | input | 1 | Transaction framing from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| idsel | input | 1 | Configuration select for this slot |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop request, active low |
| ctl_oe | output | 1 | Output enable for devsel_n, trdy_n and stop_n |
| par | output | 1 | Even parity over read data and byte enables |
| par_oe | output | 1 | Output enable for par |
| seg_hi | output | 7 | Segments of the high hex digit (bit 0 = a) |
| seg_lo | output | 7 | Segments of the low hex digit (bit 0 = a) |

## Verification
Transactions are built with several variations: single data phases, data phases held back by master wait states, and phases where FRAME# stays low. This separates a plain completion from the wait-state path and from the disconnect-with-data path. Near-miss addresses, a wrong command, a deasserted IDSEL and a non-zero type field show that decode compares every field it should. A foreign transaction whose data phase looks exactly like a port access shows whether the decoder wrongly re-arms during a busy bus. Writes with lane 0 disabled and configuration writes are followed by read-backs and display checks, which prove that they had no effect.

// File: rtl/postcode_pkg.sv
package postcode_pkg;

  localparam int unsigned SEG_W = 7;

  // cbe_n[3:1] of the address phase; bit 0 selects read (0) or write (1)
  localparam logic [2:0] CMD_HI_IO  = 3'b001;
  localparam logic [2:0] CMD_HI_CFG = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for an address phase
    ST_BUSY,   // someone else's transaction is on the bus
    ST_WAIT,   // decode cycle (medium timing)
    ST_DATA,   // devsel and trdy asserted
    ST_BACK,   // stop held until frame rises
    ST_TURN    // controls driven high before release
  } tgt_state_t;

  // hex nibble to segment pattern, bit 0 = a ... bit 6 = g, active high
  function automatic logic [SEG_W-1:0] hex_to_seg(input logic [3:0] nib);
    logic [SEG_W-1:0] s;
    unique case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/postcode_decode.sv
module postcode_decode
  import postcode_pkg::*;
#(
  parameter int unsigned AD_W      = 32,
  parameter int unsigned CBE_W     = 4,
  parameter int unsigned CFG_IDX_W = 6,
  parameter logic [AD_W-1:0] PORT_ADDR = 'h80
) (
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic                 idsel,
  input  logic [AD_W-1:0]      ad,
  input  logic [CBE_W-1:0]     cbe_n,
  output logic                 hit_io,
  output logic                 hit_cfg,
  output logic                 is_read,
  output logic [CFG_IDX_W-1:0] cfg_idx
);
  logic addr_phase;

  // an address phase shows frame low while the master is not yet ready
  assign addr_phase = !frame_n && irdy_n;

  // R2 R6: exact compare, lowest command bit left out of the match
  assign hit_io  = addr_phase && (cbe_n[3:1] == CMD_HI_IO) && (ad == PORT_ADDR);
  // R8: type-0 only, and only when this slot is selected
  assign hit_cfg = addr_phase && idsel && (cbe_n[3:1] == CMD_HI_CFG) && (ad[1:0] == 2'b00);

  assign is_read = !cbe_n[0];
  assign cfg_idx = ad[CFG_IDX_W+1:2];
endmodule

// File: rtl/postcode_cfg_space.sv
module postcode_cfg_space #(
  parameter int unsigned AD_W      = 32,
  parameter int unsigned CFG_IDX_W = 6,
  parameter logic [15:0] VENDOR_ID  = 16'h1DAC,
  parameter logic [15:0] DEVICE_ID  = 16'h0080,
  parameter logic [23:0] CLASS_CODE = 24'hFF0000,
  parameter logic [7:0]  REV_ID     = 8'h01
) (
  input  logic [CFG_IDX_W-1:0] idx,
  output logic [AD_W-1:0]      word
);
  localparam logic [CFG_IDX_W-1:0] IDX_IDENT = CFG_IDX_W'(0);
  localparam logic [CFG_IDX_W-1:0] IDX_CLASS = CFG_IDX_W'(2);

  // R9: two constant dwords; every other dword, BAR slots included, reads zero
  always_comb begin
    word = '0;
    if (idx == IDX_IDENT)      word = AD_W'({DEVICE_ID, VENDOR_ID});
    else if (idx == IDX_CLASS) word = AD_W'({CLASS_CODE, REV_ID});
  end
endmodule

// File: rtl/postcode_seg_drive.sv
module postcode_seg_drive
  import postcode_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned CODE_W = DIGITS * 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CODE_W-1:0]       code,
  output logic [DIGITS*SEG_W-1:0] seg_flat
);
  logic [SEG_W-1:0] seg_q [DIGITS];

  // R3: one registered decoder per digit
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst) seg_q[d] <= hex_to_seg(4'h0);
      else     seg_q[d] <= hex_to_seg(code[d*4 +: 4]);
    end
    assign seg_flat[d*SEG_W +: SEG_W] = seg_q[d];
  end
endmodule

// File: rtl/postcode_target.sv
module postcode_target
  import postcode_pkg::*;
#(
  parameter int unsigned AD_W      = 32,
  parameter int unsigned CBE_W     = 4,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned CFG_IDX_W = 6,
  parameter logic [AD_W-1:0] PORT_ADDR = 'h80,
  parameter logic [15:0] VENDOR_ID  = 16'h1DAC,
  parameter logic [15:0] DEVICE_ID  = 16'h0080,
  parameter logic [23:0] CLASS_CODE = 24'hFF0000,
  parameter logic [7:0]  REV_ID     = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_in,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  input  logic [CBE_W-1:0] cbe_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             idsel,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic             par,
  output logic             par_oe,
  output logic [SEG_W-1:0] seg_hi,
  output logic [SEG_W-1:0] seg_lo
);
  localparam int unsigned DIGITS = CODE_W / 4;

  tgt_state_t state;
  logic hit_io, hit_cfg, dec_read;
  logic [CFG_IDX_W-1:0] dec_idx, cyc_idx;
  logic cyc_read, cyc_cfg;
  logic [AD_W-1:0] cfg_word;
  logic [CODE_W-1:0] code_q;
  logic [DIGITS*SEG_W-1:0] seg_flat;
  logic xfer;

  postcode_decode #(
    .AD_W(AD_W), .CBE_W(CBE_W), .CFG_IDX_W(CFG_IDX_W), .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel), .ad(ad_in), .cbe_n(cbe_n),
    .hit_io(hit_io), .hit_cfg(hit_cfg), .is_read(dec_read), .cfg_idx(dec_idx)
  );

  postcode_cfg_space #(
    .AD_W(AD_W), .CFG_IDX_W(CFG_IDX_W), .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE), .REV_ID(REV_ID)
  ) u_cfg (
    .idx(cyc_idx), .word(cfg_word)
  );

  postcode_seg_drive #(.DIGITS(DIGITS)) u_seg (
    .clk(clk), .rst(rst), .code(code_q), .seg_flat(seg_flat)
  );

  assign seg_lo = seg_flat[SEG_W-1:0];
  assign seg_hi = seg_flat[2*SEG_W-1:SEG_W];

  // the only data phase completes when the master is ready while trdy is low
  assign xfer = (state == ST_DATA) && !irdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ctl_oe   <= 1'b0;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
      par      <= 1'b0;
      par_oe   <= 1'b0;
      cyc_read <= 1'b0;
      cyc_cfg  <= 1'b0;
      cyc_idx  <= '0;
      code_q   <= '0;
    end else begin
      par_oe <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            if (hit_io || hit_cfg) begin
              state    <= ST_WAIT;
              cyc_read <= dec_read;
              cyc_cfg  <= hit_cfg;
              cyc_idx  <= dec_idx;
            end else begin
              state <= ST_BUSY;   // R7
            end
          end
        end
        ST_BUSY: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        ST_WAIT: begin
          state    <= ST_DATA;
          devsel_n <= 1'b0;
          trdy_n   <= 1'b0;
          stop_n   <= frame_n;   // R12: more phases wanted, disconnect with data
          ctl_oe   <= 1'b1;
          ad_oe    <= cyc_read;
          ad_out   <= cyc_cfg ? cfg_word : AD_W'(code_q);
        end
        ST_DATA: begin
          if (xfer) begin
            ad_oe  <= 1'b0;
            trdy_n <= 1'b1;
            par_oe <= cyc_read;
            par    <= ^{ad_out, cbe_n};
            if (!cyc_read && !cyc_cfg && !cbe_n[0]) code_q <= ad_in[CODE_W-1:0];
            if (!frame_n) begin
              state  <= ST_BACK;
              stop_n <= 1'b0;
            end else begin
              state    <= ST_TURN;
              devsel_n <= 1'b1;
              stop_n   <= 1'b1;
            end
          end
        end
        ST_BACK: begin
          if (frame_n) begin
            state    <= ST_TURN;
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
          end
        end
        ST_TURN: begin
          state  <= ST_IDLE;
          ctl_oe <= 1'b0;       // R14
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/postcode_target_chk.sv
module postcode_target_chk #(
  parameter int unsigned AD_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_n,
  input logic            irdy_n,
  input logic [AD_W-1:0] ad_out,
  input logic            ad_oe,
  input logic            devsel_n,
  input logic            trdy_n,
  input logic            stop_n,
  input logic            ctl_oe,
  input logic            par_oe
);
  assert_trdy_inside_claim_R2: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> (!devsel_n && ctl_oe));

  assert_medium_devsel_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> ($past(frame_n, 2) == 1'b0 && $past(irdy_n, 2) == 1'b1));

  assert_read_drive_claimed_R5: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!devsel_n && !trdy_n));

  assert_read_data_held_R5: assert property (@(posedge clk) disable iff (rst)
    (ad_oe && $past(ad_oe)) |-> $stable(ad_out));

  assert_par_after_read_R11: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> $past(!trdy_n && !irdy_n && ad_oe));

  assert_par_one_clock_R11: assert property (@(posedge clk) disable iff (rst)
    par_oe |=> !par_oe);

  assert_stop_claimed_R12: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> !devsel_n);

  assert_release_after_high_R14: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_oe) |-> $past(devsel_n && trdy_n && stop_n));
endmodule

bind postcode_target postcode_target_chk #(.AD_W(AD_W)) i_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_out(ad_out),
  .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .ctl_oe(ctl_oe), .par_oe(par_oe)
);

// File: tb/test_postcode_target.sv
module test_postcode_target;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst;
  logic [31:0] ad_in;
  logic [3:0]  cbe_n;
  logic        frame_n, irdy_n, idsel;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, par, par_oe;
  logic [6:0]  seg_hi, seg_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model_code = 8'h00;
  logic [7:0] model_seg_code;

  localparam logic [31:0] EXP_IDENT = 32'h0080_1DAC;
  localparam logic [31:0] EXP_CLASS = 32'hFF00_0001;

  postcode_target i_postcode_target (
    .clk(clk), .rst(rst), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
    .par(par), .par_oe(par_oe), .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  function automatic logic [6:0] segtab(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
      4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
      4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
      4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference display: the digits follow the modelled byte one clock later
  always @(posedge clk) begin
    if (rst) model_seg_code <= 8'h00;
    else     model_seg_code <= model_code;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 seg_lo per clock", 32'(seg_lo), 32'(segtab(model_seg_code[3:0])));
      chk("R3 seg_hi per clock", 32'(seg_hi), 32'(segtab(model_seg_code[7:4])));
    end
  end

  task automatic xact(input string tag, input logic [3:0] cmd, input logic [31:0] addr,
                      input logic sel, input logic [3:0] be, input logic [31:0] wdata,
                      input int waits, input bit burst, input bit claim,
                      input logic [31:0] exp_rd);
    bit rd = !cmd[0];
    logic exp_par;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    idsel = 1'b0; ad_in = rd ? 32'h0 : wdata; cbe_n = be;
    if (!claim) begin
      frame_n = 1'b0; irdy_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk({tag, " devsel_n stays high"}, 32'(devsel_n), 32'd1);
      end
      frame_n = 1'b1; irdy_n = 1'b0;
      @(negedge clk);
      irdy_n = 1'b1;
      @(negedge clk);
      chk({tag, " ctl_oe idle"}, 32'(ctl_oe), 32'd0);
      return;
    end
    if (waits > 0) begin frame_n = 1'b0; irdy_n = 1'b1; end
    else begin frame_n = burst ? 1'b0 : 1'b1; irdy_n = 1'b0; end
    @(negedge clk);
    chk({tag, " R2 devsel_n"}, 32'(devsel_n), 32'd0);
    chk({tag, " R2 trdy_n"}, 32'(trdy_n), 32'd0);
    chk({tag, " R2 ctl_oe"}, 32'(ctl_oe), 32'd1);
    chk({tag, " R12 stop_n"}, 32'(stop_n), (burst || waits > 0) ? 32'd0 : 32'd1);
    chk({tag, " R5 ad_oe"}, 32'(ad_oe), 32'(rd));
    if (rd) chk({tag, " R5 R9 read data"}, ad_out, exp_rd);
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      chk({tag, " R13 trdy_n held"}, 32'(trdy_n), 32'd0);
      chk({tag, " R13 devsel_n held"}, 32'(devsel_n), 32'd0);
    end
    if (waits > 0) begin irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1; end
    exp_par = ^{ad_out, be};
    @(negedge clk);
    if (cmd == 4'b0011 && !be[0]) model_code = wdata[7:0];
    chk({tag, " R13 trdy_n after transfer"}, 32'(trdy_n), 32'd1);
    chk({tag, " R11 par_oe"}, 32'(par_oe), 32'(rd));
    if (rd) chk({tag, " R11 par value"}, 32'(par), 32'(exp_par));
    if (burst) begin
      chk({tag, " R12 stop_n held"}, 32'(stop_n), 32'd0);
      chk({tag, " R12 devsel_n held"}, 32'(devsel_n), 32'd0);
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
    end else begin
      irdy_n = 1'b1;
    end
    chk({tag, " R14 devsel_n high"}, 32'(devsel_n), 32'd1);
    chk({tag, " R14 stop_n high"}, 32'(stop_n), 32'd1);
    chk({tag, " R14 ctl_oe still on"}, 32'(ctl_oe), 32'd1);
    @(negedge clk);
    chk({tag, " R14 ctl_oe released"}, 32'(ctl_oe), 32'd0);
    chk({tag, " R11 par_oe single"}, 32'(par_oe), 32'd0);
  endtask

  task automatic reset_checks(input string tag);
    chk({tag, " R1 devsel_n"}, 32'(devsel_n), 32'd1);
    chk({tag, " R1 trdy_n"}, 32'(trdy_n), 32'd1);
    chk({tag, " R1 stop_n"}, 32'(stop_n), 32'd1);
    chk({tag, " R1 oes"}, {29'd0, ctl_oe, ad_oe, par_oe}, 32'd0);
    chk({tag, " R1 seg_lo"}, 32'(seg_lo), 32'h3F);
    chk({tag, " R1 seg_hi"}, 32'(seg_hi), 32'h3F);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ad_in = '0; cbe_n = 4'hF; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
    repeat (3) @(negedge clk);
    reset_checks("in reset");
    rst = 1'b0;
    @(negedge clk);
    reset_checks("after reset");

    xact("R2 R3 port write", 4'b0011, 32'h80, 1'b0, 4'b1110, 32'hA5A5_A55A, 0, 1'b0, 1'b1, 32'h0);
    chk("R3 seg_hi shows 5", 32'(seg_hi), 32'h6D);
    chk("R3 seg_lo shows A", 32'(seg_lo), 32'h77);
    xact("R5 port read", 4'b0010, 32'h80, 1'b0, 4'b0000, 32'h0, 0, 1'b0, 1'b1, 32'h5A);
    xact("R13 write with waits", 4'b0011, 32'h80, 1'b0, 4'b1110, 32'h0000_00C3, 2, 1'b0, 1'b1, 32'h0);
    xact("R12 disconnect write", 4'b0011, 32'h80, 1'b0, 4'b0000, 32'h0000_007E, 0, 1'b1, 1'b1, 32'h0);
    xact("R4 lane 0 off", 4'b0011, 32'h80, 1'b0, 4'b1111, 32'h0000_0011, 0, 1'b0, 1'b1, 32'h0);
    xact("R4 readback", 4'b0010, 32'h80, 1'b0, 4'b0000, 32'h0, 0, 1'b0, 1'b1, 32'h7E);
    xact("R6 io 0x84", 4'b0011, 32'h84, 1'b0, 4'b1110, 32'h22, 0, 1'b0, 1'b0, 32'h0);
    xact("R6 io 0x81", 4'b0011, 32'h81, 1'b0, 4'b1110, 32'h23, 0, 1'b0, 1'b0, 32'h0);
    xact("R6 io read 0x180", 4'b0010, 32'h180, 1'b0, 4'b0000, 32'h0, 0, 1'b0, 1'b0, 32'h0);
    xact("R6 memory write 0x80", 4'b0111, 32'h80, 1'b0, 4'b1110, 32'h24, 0, 1'b0, 1'b0, 32'h0);
    xact("R7 foreign with lookalike phase", 4'b0111, 32'h1000, 1'b0, 4'b0011, 32'h80, 0, 1'b0, 1'b0, 32'h0);
    xact("R9 cfg ident", 4'b1010, 32'h00, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b1, EXP_IDENT);
    xact("R9 cfg class", 4'b1010, 32'h08, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b1, EXP_CLASS);
    xact("R9 cfg bar first", 4'b1010, 32'h10, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b1, 32'h0);
    xact("R9 cfg bar last", 4'b1010, 32'h24, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b1, 32'h0);
    xact("R9 cfg dword1", 4'b1010, 32'h04, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b1, 32'h0);
    xact("R8 cfg idsel low", 4'b1010, 32'h00, 1'b0, 4'b0000, 32'h0, 0, 1'b0, 1'b0, 32'h0);
    xact("R8 cfg type field 01", 4'b1010, 32'h01, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b0, 32'h0);
    xact("R10 cfg write", 4'b1011, 32'h00, 1'b1, 4'b0000, 32'hFFFF_FFFF, 0, 1'b0, 1'b1, 32'h0);
    xact("R10 cfg readback", 4'b1010, 32'h00, 1'b1, 4'b0000, 32'h0, 0, 1'b0, 1'b1, EXP_IDENT);
    xact("R10 port unchanged", 4'b0010, 32'h80, 1'b0, 4'b0000, 32'h0, 0, 1'b0, 1'b1, 32'h7E);
    xact("R11 R12 disconnect read", 4'b0010, 32'h80, 1'b0, 4'b0000, 32'h0, 0, 1'b1, 1'b1, 32'h7E);
    xact("R3 write 0x00", 4'b0011, 32'h80, 1'b0, 4'b0110, 32'h0000_0000, 0, 1'b0, 1'b1, 32'h0);
    xact("R11 read odd enables with wait", 4'b0010, 32'h80, 1'b0, 4'b1011, 32'h0, 1, 1'b0, 1'b1, 32'h0);
    xact("R11 cfg class read parity", 4'b1010, 32'h08, 1'b1, 4'b0001, 32'h0, 0, 1'b0, 1'b1, EXP_CLASS);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule